// File: doc/BRIEF.md
# Machine Interrupt Pending and Priority Unit

This block keeps the machine-level interrupt enable and pending state for a small 32-bit core. Three sources are implemented: a timer source at bit 7, driven by comparing a 64-bit running time against a 64-bit compare value, and two event sources at bits 16 and 17. Bit 16 marks an external input edge and bit 17 marks an incoming message. Each event arrives as a one-cycle strobe. The timer bit follows the comparison level on every cycle. The event bits are sticky until software writes them.

On each evaluation strobe from the core, for example after a CSR access instruction retires, the unit looks at the enabled and pending bits, but only when the global interrupt enable is set. It scans them in a fixed rank order and, one cycle later, raises a single-cycle trap request with an encoded cause. Separately, the unit holds a waiting flag that a wait-for-interrupt entry sets. An enabled event strobe clears that flag and produces a one-cycle wake pulse.

Top module: `irq_pend_arb`

## Requirements
- R1: During reset, pend_o, enab_o, cause_o, trap_o, wake_o and wait_o are all zero.
- R2: A write with csr_sel_i=0 (enable register) stores only bits 7, 16 and 17 of csr_wdata_i into enab_o. Every other bit of enab_o reads zero.
- R3: One cycle after the inputs are sampled, pend_o[7] is 1 in two cases: the upper 32 bits of time_i and cmp_i are equal and the lower 32 bits of time_i are greater than or equal to those of cmp_i, or the upper 32 bits of time_i exceed those of cmp_i. In every other case pend_o[7] is 0.
- R4: A strobe on ev_in_i sets pend_o[16], and a strobe on ev_msg_i sets pend_o[17], at the next edge. Each bit then stays set until software writes it.
- R5: A write with csr_sel_i=1 (pending register) loads bits 16 and 17 of csr_wdata_i into pend_o[16] and pend_o[17]. pend_o[7] is not affected by the write, and all other bits of pend_o stay zero.
- R6: If an event strobe and a pending-register write that clears the same bit occur in the same cycle, the bit ends up set.
- R7: While glb_en_i is 0, an evaluation strobe raises no trap, and the pending bits keep updating.
- R8: Enabled pending bits are ranked 11, 3, 7, 9, 1, 5, 13, 16, 17, highest first, so among the implemented bits 7 beats 16 and 16 beats 17. cause_o equals 0x80000000 plus the index of the winning bit.
- R9: trap_o is 1 for exactly the one cycle after an evaluation strobe, and only when glb_en_i is 1 and at least one bit is both enabled and pending. cause_o holds its value between traps.
- R10: While wait_o is 1, an event strobe whose own enable bit is set produces wake_o=1 for one cycle and clears wait_o at the same edge. A strobe whose enable bit is clear leaves wait_o set and wake_o at 0.
- R11: A wfi_i strobe sets wait_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 1 | Write target: 0 enable register, 1 pending register |
| csr_wdata_i | input | 32 | CSR write data |
| time_i | input | 64 | Current time value |
| cmp_i | input | 64 | Timer compare value |
| ev_in_i | input | 1 | External input event strobe (bit 16) |
| ev_msg_i | input | 1 | Message receive event strobe (bit 17) |
| glb_en_i | input | 1 | Global machine interrupt enable |
| eval_i | input | 1 | Evaluation strobe, for example after a CSR instruction |
| wfi_i | input | 1 | Core enters its wait-for-interrupt state |
| pend_o | output | 32 | Pending register |
| enab_o | output | 32 | Enable register |
| trap_o | output | 1 | Single-cycle trap request |
| cause_o | output | 32 | Trap cause of the last trap |
| wake_o | output | 1 | Single-cycle wake pulse |
| wait_o | output | 1 | Waiting flag |

## Verification
The bench steps the timer comparison across the boundaries of the high and low words: lows equal, lows one apart, a high word that differs while the low word points the other way, and the all-ones extremes. A design that compared the words wrongly, or treated the two halves as one unsigned value in the wrong order, would set bit 7 on the wrong side of one of these pairs.

It also drives a clearing write in the same cycle as an event strobe. A design that let the write win would drop the event.

It walks the rank order by removing winners one at a time, and it checks that no trap is raised when the global enable is clear. A design with a swapped rank or a missing gate would report the wrong cause or trap spuriously.

Finally, it sends an event whose enable bit is clear while the core is waiting. A wake that ignored the enable would restart the core.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   localparam int unsigned PRIO_N = 9;
   localparam int unsigned IDX_W  = 5;

   typedef enum logic {
      CSR_ENAB = 1'b0,
      CSR_PEND = 1'b1
   } csr_sel_e;

   // rank 0 is the highest priority
   function automatic logic [IDX_W-1:0] prio_bit(input int unsigned rank);
      logic [IDX_W-1:0] b;
      case (rank)
         0:       b = 5'd11;
         1:       b = 5'd3;
         2:       b = 5'd7;
         3:       b = 5'd9;
         4:       b = 5'd1;
         5:       b = 5'd5;
         6:       b = 5'd13;
         7:       b = 5'd16;
         default: b = 5'd17;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/irq_time_cmp.sv
module irq_time_cmp #(
   parameter int unsigned TIME_W    = 64,
   parameter bit          SPLIT_CMP = 1'b1
) (
   input  logic [TIME_W-1:0] time_i,
   input  logic [TIME_W-1:0] cmp_i,
   output logic              hit_o
);
   localparam int unsigned HALF_W = TIME_W / 2;

   if (TIME_W % 2 != 0) begin : g_bad_w
      $error("irq_time_cmp: TIME_W must be even");
   end

   if (SPLIT_CMP) begin : g_split
      logic hi_eq, hi_gt, lo_ge;
      assign hi_eq = time_i[TIME_W-1:HALF_W] == cmp_i[TIME_W-1:HALF_W];
      assign hi_gt = time_i[TIME_W-1:HALF_W] >  cmp_i[TIME_W-1:HALF_W];
      assign lo_ge = time_i[HALF_W-1:0]      >= cmp_i[HALF_W-1:0];
      assign hit_o = (hi_eq & lo_ge) | hi_gt;
   end else begin : g_full
      assign hit_o = time_i >= cmp_i;
   end
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned TMR_BIT     = 7,
   parameter logic [31:0] STICKY_MASK = 32'h0003_0000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_enab_i,
   input  logic            wr_pend_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            tmr_hit_i,
   input  logic [XLEN-1:0] ev_vec_i,
   output logic [XLEN-1:0] pend_o,
   output logic [XLEN-1:0] enab_o
);
   localparam logic [XLEN-1:0] STICKY = XLEN'(STICKY_MASK);
   localparam logic [XLEN-1:0] ENAB_MASK = STICKY | (XLEN'(1) << TMR_BIT);

   if (STICKY[TMR_BIT]) begin : g_bad_mask
      $error("irq_csr_regs: timer bit may not be sticky");
   end

   logic [XLEN-1:0] pend_q;
   logic [XLEN-1:0] enab_q;

   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      if (b == TMR_BIT) begin : g_tmr
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pend_q[b] <= 1'b0;
            else         pend_q[b] <= tmr_hit_i;
         end
      end else if (STICKY[b]) begin : g_evt
         always_ff @(posedge clk_i) begin
            if (!rst_ni)        pend_q[b] <= 1'b0;
            else if (wr_pend_i) pend_q[b] <= ev_vec_i[b] | wdata_i[b];
            else                pend_q[b] <= ev_vec_i[b] | pend_q[b];
         end
      end else begin : g_none
         assign pend_q[b] = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        enab_q <= '0;
      else if (wr_enab_i) enab_q <= wdata_i & ENAB_MASK;
   end

   assign pend_o = pend_q;
   assign enab_o = enab_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_pend_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0]  act_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      // walk from lowest rank up so the highest active rank is left last
      for (int k = PRIO_N - 1; k >= 0; k--) begin
         if (act_i[prio_bit(k)]) begin
            found_o = 1'b1;
            idx_o   = prio_bit(k);
         end
      end
   end
endmodule

// File: rtl/irq_wake.sv
module irq_wake #(
   parameter int unsigned XLEN        = 32,
   parameter logic [31:0] STICKY_MASK = 32'h0003_0000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wfi_i,
   input  logic [XLEN-1:0] ev_vec_i,
   input  logic [XLEN-1:0] enab_i,
   output logic            wake_o,
   output logic            wait_o
);
   localparam logic [XLEN-1:0] STICKY = XLEN'(STICKY_MASK);

   logic wait_q, wake_q, wake_d;

   assign wake_d = wait_q & (|(ev_vec_i & enab_i & STICKY));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wait_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         wake_q <= wake_d;
         if (wake_d)     wait_q <= 1'b0;
         else if (wfi_i) wait_q <= 1'b1;
      end
   end

   assign wake_o = wake_q;
   assign wait_o = wait_q;
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
   import irq_pend_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned TMR_BIT   = 7,
   parameter int unsigned EXT_BIT   = 16,
   parameter int unsigned MSG_BIT   = 17,
   parameter bit          SPLIT_CMP = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              csr_we_i,
   input  logic              csr_sel_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic [TIME_W-1:0] cmp_i,
   input  logic              ev_in_i,
   input  logic              ev_msg_i,
   input  logic              glb_en_i,
   input  logic              eval_i,
   input  logic              wfi_i,
   output logic [XLEN-1:0]   pend_o,
   output logic [XLEN-1:0]   enab_o,
   output logic              trap_o,
   output logic [XLEN-1:0]   cause_o,
   output logic              wake_o,
   output logic              wait_o
);
   localparam logic [31:0] STICKY_MASK = (32'd1 << EXT_BIT) | (32'd1 << MSG_BIT);

   if (XLEN < 18) begin : g_bad_xlen
      $error("irq_pend_arb: XLEN must hold bit 17");
   end
   if (EXT_BIT == MSG_BIT || EXT_BIT == TMR_BIT || MSG_BIT == TMR_BIT) begin : g_bad_bits
      $error("irq_pend_arb: source bits must differ");
   end

   logic            tmr_hit;
   logic [XLEN-1:0] ev_vec;
   logic [XLEN-1:0] pend_q, enab_q;
   logic            found;
   logic [IDX_W-1:0] win_idx;
   logic            take;
   logic            trap_q;
   logic [XLEN-1:0] cause_q, cause_d;
   logic            wr_enab, wr_pend;

   assign wr_enab = csr_we_i & (csr_sel_e'(csr_sel_i) == CSR_ENAB);
   assign wr_pend = csr_we_i & (csr_sel_e'(csr_sel_i) == CSR_PEND);

   always_comb begin
      ev_vec          = '0;
      ev_vec[EXT_BIT] = ev_in_i;
      ev_vec[MSG_BIT] = ev_msg_i;
   end

   irq_time_cmp #(
      .TIME_W   (TIME_W),
      .SPLIT_CMP(SPLIT_CMP)
   ) u_cmp (
      .time_i(time_i),
      .cmp_i (cmp_i),
      .hit_o (tmr_hit)
   );

   irq_csr_regs #(
      .XLEN       (XLEN),
      .TMR_BIT    (TMR_BIT),
      .STICKY_MASK(STICKY_MASK)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_enab_i(wr_enab),
      .wr_pend_i(wr_pend),
      .wdata_i  (csr_wdata_i),
      .tmr_hit_i(tmr_hit),
      .ev_vec_i (ev_vec),
      .pend_o   (pend_q),
      .enab_o   (enab_q)
   );

   irq_prio_sel #(
      .XLEN(XLEN)
   ) u_sel (
      .act_i  (pend_q & enab_q),
      .found_o(found),
      .idx_o  (win_idx)
   );

   irq_wake #(
      .XLEN       (XLEN),
      .STICKY_MASK(STICKY_MASK)
   ) u_wake (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wfi_i   (wfi_i),
      .ev_vec_i(ev_vec),
      .enab_i  (enab_q),
      .wake_o  (wake_o),
      .wait_o  (wait_o)
   );

   assign take = eval_i & glb_en_i & found;

   always_comb begin
      cause_d                = '0;
      cause_d[XLEN-1]        = 1'b1;
      cause_d[IDX_W-1:0]     = win_idx;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         trap_q  <= 1'b0;
         cause_q <= '0;
      end else begin
         trap_q <= take;
         if (take) cause_q <= cause_d;
      end
   end

   assign pend_o  = pend_q;
   assign enab_o  = enab_q;
   assign trap_o  = trap_q;
   assign cause_o = cause_q;
endmodule

// File: rtl/irq_pend_arb_chk.sv
module irq_pend_arb_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned TIME_W = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              csr_we_i,
   input logic              csr_sel_i,
   input logic [TIME_W-1:0] time_i,
   input logic [TIME_W-1:0] cmp_i,
   input logic              ev_in_i,
   input logic              ev_msg_i,
   input logic              glb_en_i,
   input logic              eval_i,
   input logic [XLEN-1:0]   pend_o,
   input logic [XLEN-1:0]   enab_o,
   input logic              trap_o,
   input logic [XLEN-1:0]   cause_o,
   input logic              wake_o,
   input logic              wait_o
);
   localparam logic [XLEN-1:0] LIVE = XLEN'(32'h0003_0080);

   p_unimpl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_o & ~LIVE) == '0) && ((enab_o & ~LIVE) == '0));

   p_timer_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> pend_o[7] == $past(time_i >= cmp_i));

   p_sticky_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[16] && !(csr_we_i && csr_sel_i)) |=> pend_o[16]);

   p_sticky_msg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[17] && !(csr_we_i && csr_sel_i)) |=> pend_o[17]);

   p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_in_i || ev_msg_i) |=> (pend_o[16] || !$past(ev_in_i)) && (pend_o[17] || !$past(ev_msg_i)));

   p_trap_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> $past(eval_i) && $past(glb_en_i));

   p_cause_form_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> cause_o[XLEN-1] && (cause_o[XLEN-2:0] == 7 || cause_o[XLEN-2:0] == 16 ||
                                     cause_o[XLEN-2:0] == 17));

   p_cause_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trap_o |=> trap_o || $stable(cause_o));

   p_wake_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> !wait_o && $past(wait_o));
endmodule

bind irq_pend_arb irq_pend_arb_chk #(
   .XLEN  (XLEN),
   .TIME_W(TIME_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .csr_we_i (csr_we_i),
   .csr_sel_i(csr_sel_i),
   .time_i   (time_i),
   .cmp_i    (cmp_i),
   .ev_in_i  (ev_in_i),
   .ev_msg_i (ev_msg_i),
   .glb_en_i (glb_en_i),
   .eval_i   (eval_i),
   .pend_o   (pend_o),
   .enab_o   (enab_o),
   .trap_o   (trap_o),
   .cause_o  (cause_o),
   .wake_o   (wake_o),
   .wait_o   (wait_o)
);

// File: tb/irq_pend_arb_tb_top.sv
`timescale 1ns/1ps
module irq_pend_arb_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        csr_we_i = 1'b0;
   logic        csr_sel_i = 1'b0;
   logic [31:0] csr_wdata_i = '0;
   logic [63:0] time_i = '0;
   logic [63:0] cmp_i = '1;
   logic        ev_in_i = 1'b0;
   logic        ev_msg_i = 1'b0;
   logic        glb_en_i = 1'b0;
   logic        eval_i = 1'b0;
   logic        wfi_i = 1'b0;
   logic [31:0] pend_o, enab_o, cause_o;
   logic        trap_o, wake_o, wait_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   irq_pend_arb dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
      .csr_wdata_i(csr_wdata_i), .time_i(time_i), .cmp_i(cmp_i), .ev_in_i(ev_in_i),
      .ev_msg_i(ev_msg_i), .glb_en_i(glb_en_i), .eval_i(eval_i), .wfi_i(wfi_i),
      .pend_o(pend_o), .enab_o(enab_o), .trap_o(trap_o), .cause_o(cause_o),
      .wake_o(wake_o), .wait_o(wait_o)
   );

   // time, compare, expected timer pending bit
   typedef logic [128:0] vec_t;
   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1},
      {64'h0000_0000_0000_0005, 64'h0000_0000_0000_0006, 1'b0},
      {64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1},
      {64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 1'b0},
      {64'h0000_0002_0000_000A, 64'h0000_0002_0000_000A, 1'b1},
      {64'h0000_0002_0000_0009, 64'h0000_0002_0000_000A, 1'b0},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
      {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_i);
   endtask

   task automatic csr_wr(input logic sel, input logic [31:0] d);
      csr_we_i = 1'b1; csr_sel_i = sel; csr_wdata_i = d;
      tick();
      csr_we_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 pend", pend_o, 0);
      chk("R1 enab", enab_o, 0);
      chk("R1 trap/wake/wait", {trap_o, wake_o, wait_o}, 0);
      chk("R1 cause", cause_o, 0);
      rst_ni = 1'b1;
      tick();

      // R3 timer comparison table
      for (int i = 0; i < NVEC; i++) begin
         time_i = VEC[i][128:65];
         cmp_i  = VEC[i][64:1];
         tick();
         chk($sformatf("R3 vec%0d", i), pend_o[7], VEC[i][0]);
      end
      time_i = '0; cmp_i = '1;
      tick();

      // R2 enable mask
      csr_wr(1'b0, 32'hFFFF_FFFF);
      chk("R2 enab mask", enab_o, 32'h0003_0080);

      // R4 sticky event
      ev_in_i = 1'b1; tick(); ev_in_i = 1'b0;
      chk("R4 set bit16", pend_o, 32'h0001_0000);
      repeat (3) tick();
      chk("R4 hold bit16", pend_o, 32'h0001_0000);

      // R7 no trap with global enable clear
      eval_i = 1'b1; tick(); eval_i = 1'b0;
      chk("R7 no trap", trap_o, 0);
      ev_msg_i = 1'b1; tick(); ev_msg_i = 1'b0;
      chk("R7 pend updates", pend_o, 32'h0003_0000);

      // R5 pending write
      time_i = 64'd10; cmp_i = 64'd3;
      tick();
      csr_wr(1'b1, 32'h0000_0000);
      chk("R5 clear keeps timer", pend_o, 32'h0000_0080);
      csr_wr(1'b1, 32'hFFFF_FFFF);
      chk("R5 set masks", pend_o, 32'h0003_0080);
      csr_wr(1'b1, 32'h0000_0000);

      // R6 event beats clear
      ev_msg_i = 1'b1;
      csr_wr(1'b1, 32'h0000_0000);
      ev_msg_i = 1'b0;
      chk("R6 event wins", pend_o, 32'h0002_0080);
      ev_in_i = 1'b1; tick(); ev_in_i = 1'b0;

      // R8 / R9 ranking and pulse
      glb_en_i = 1'b1;
      eval_i = 1'b1; tick(); eval_i = 1'b0;
      chk("R9 trap pulse", trap_o, 1);
      chk("R8 cause timer", cause_o, 32'h8000_0007);
      tick();
      chk("R9 trap ends", trap_o, 0);
      chk("R9 cause holds", cause_o, 32'h8000_0007);
      cmp_i = '1; tick();
      eval_i = 1'b1; tick(); eval_i = 1'b0;
      chk("R8 cause bit16", {31'd0, trap_o, cause_o}, {31'd1, 32'h8000_0010});
      csr_wr(1'b1, 32'h0002_0000);
      eval_i = 1'b1; tick(); eval_i = 1'b0;
      chk("R8 cause bit17", {31'd0, trap_o, cause_o}, {31'd1, 32'h8000_0011});
      csr_wr(1'b0, 32'h0001_0080);
      eval_i = 1'b1; tick(); eval_i = 1'b0;
      chk("R9 none enabled", trap_o, 0);
      glb_en_i = 1'b0;

      // R11 / R10 wait and wake
      csr_wr(1'b0, 32'h0000_0000);
      wfi_i = 1'b1; tick(); wfi_i = 1'b0;
      chk("R11 wait set", wait_o, 1);
      ev_in_i = 1'b1; tick(); ev_in_i = 1'b0;
      chk("R10 disabled no wake", {wake_o, wait_o}, 2'b01);
      csr_wr(1'b0, 32'h0001_0000);
      ev_in_i = 1'b1; tick(); ev_in_i = 1'b0;
      chk("R10 wake", {wake_o, wait_o}, 2'b10);
      tick();
      chk("R10 wake pulse ends", wake_o, 0);

      finish_run();
   end
endmodule